// File: doc/BRIEF.md
# Two-Thread Backend Entry Allocator

This block decides, once per clock, which of two per-thread micro-op queues may place its head micro-op into the shared backend buffers. There are three shared buffers: a reorder buffer, a load buffer and a store buffer. The block keeps six occupancy counters, one per thread per buffer. Allocation raises a counter. Per-thread release counts from retirement lower it. The buffer storage and register renaming sit outside this block. A grant only tells the owning queue to pop its head entry in that cycle.

Fairness comes from occupancy ceilings that depend on the operating mode. With both threads running, each thread may fill at most half of every buffer, so neither thread can starve or deadlock the other. When one thread halts, the mode request names the surviving thread. That thread then gets the whole of every buffer, and the halted thread receives nothing. Entering a single-thread mode takes effect at once. Returning to two-thread operation waits until every counter has drained to its half share. While the return is pending, only the previously running thread may allocate, and it is held to the half share.

Between two eligible threads the grant alternates every cycle. A thread that is stalled (no valid op, or no room for its op) or inactive is skipped, and the other thread is serviced.

Top module: `thread_share_alloc`

## Requirements
- R1: On reset, all six occupancy counters read zero, the effective mode is two-thread (code 00), and the first cycle in which both threads are eligible grants thread 0.
- R2: In two-thread mode (code 00), no thread's occupancy of any buffer exceeds half that buffer's capacity (63 reorder, 24 load and 12 store entries at default sizes).
- R3: In single-thread mode, the active thread may fill each buffer to its full capacity and the other thread receives no grant. Mode request 01 keeps only thread 0 and request 10 keeps only thread 1.
- R4: A thread is granted only if its valid bit is set, it is active, and its reorder count is below its ceiling. Kind 01 (load) additionally needs the load count below its ceiling, and kind 10 (store) needs the store count below its ceiling. Kinds 00 and 11 need only a reorder entry. Ceilings are checked against the counts held at the start of the cycle, before that cycle's releases.
- R5: When both threads are eligible, the grant goes to the thread that was not granted most recently.
- R6: When exactly one thread is eligible, it is granted. At most one thread is granted per cycle, and no grant is given when neither thread is eligible.
- R7: In each cycle, each counter becomes its old value, plus one if that thread allocated into that buffer, minus that thread's release count for that buffer. Both updates apply in the same cycle.
- R8: A request for a single-thread mode (01 or 10) becomes the effective mode on the next clock edge, from any mode.
- R9: A request for two-thread mode made from a single-thread mode takes effect only on the edge after a cycle in which all six counts are at or below their half shares. Until then, the effective mode is unchanged and the running thread's ceilings are the half shares.
- R10: Mode request 11 is reserved and leaves the effective mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested mode: 00 both threads, 01 thread 0 only, 10 thread 1 only, 11 reserved |
| uop_vld | input | 2 | Bit t: thread t's queue has a micro-op at its head |
| uop_kind | input | 4 | Bits 2t+1:2t give thread t's op kind: 01 load, 10 store, otherwise plain |
| rob_rel | input | 2*REL_W | Reorder entries released this cycle, field t for thread t |
| ld_rel | input | 2*REL_W | Load entries released this cycle, field t for thread t |
| st_rel | input | 2*REL_W | Store entries released this cycle, field t for thread t |
| grant | output | 2 | Bit t: thread t's head op is allocated this cycle (combinational) |
| mode_now | output | 2 | Effective mode, same encoding as mode_req |
| rob_used | output | 2*ROB_W | Reorder occupancy, field t for thread t |
| ld_used | output | 2*LD_W | Load occupancy, field t for thread t |
| st_used | output | 2*ST_W | Store occupancy, field t for thread t |

## Verification
A counter that drifts becomes visible on the occupancy outputs on the edge after the faulty update. The same error also shows up later as a missing grant once a ceiling is reached, or as a grant where none should be. A wrong turn bit gives two consecutive grants to the same thread while both threads are eligible, and it is visible within one cycle of that pairing. A faulty mode register either lets a thread past its half share during a pending return, which shows on the occupancy outputs, or reports the wrong code on `mode_now` on the very next edge. The bench runs a reduced configuration through every mode sequence, with fill and drain phases, and compares each cycle's grant, mode and counts with values it computes from the requirements.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int NTHR = 2;

  typedef enum logic [1:0] {
    MODE_BOTH  = 2'b00,
    MODE_SOLO0 = 2'b01,
    MODE_SOLO1 = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    KIND_PLAIN  = 2'b00,
    KIND_LOAD   = 2'b01,
    KIND_STORE  = 2'b10,
    KIND_PLAINX = 2'b11
  } kind_e;
endpackage

// File: rtl/tsa_occ_counter.sv
module tsa_occ_counter #(
  parameter int CAP   = 126,
  parameter int REL_W = 2,
  parameter int CW    = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic [REL_W-1:0] dec_i,
  output logic [CW-1:0]    cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   sum;
  logic          upd_en;

  always_comb begin
    sum    = {1'b0, cnt_q} + (CW + 1)'(inc_i) - (CW + 1)'(dec_i);
    cnt_d  = sum[CW-1:0];
    upd_en = inc_i | (dec_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (upd_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R7
  rel_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CW + 1)'(dec_i) <= {1'b0, cnt_q});

  // R7
  cnt_in_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= CAP);
endmodule

// File: rtl/tsa_mode_ctl.sv
module tsa_mode_ctl
  import tsa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_i,
  input  logic       all_low_i,
  output mode_e      mode_o,
  output logic       pend_o
);
  mode_e mode_q, mode_d;
  mode_e req_m;
  logic  mode_en;

  always_comb begin
    req_m  = mode_e'(req_i);
    mode_d = mode_q;
    pend_o = 1'b0;
    unique case (req_m)
      MODE_SOLO0, MODE_SOLO1: mode_d = req_m;
      MODE_BOTH: begin
        if (mode_q != MODE_BOTH) begin
          pend_o = 1'b1;
          if (all_low_i) mode_d = MODE_BOTH;
        end
      end
      default: mode_d = mode_q;
    endcase
    mode_en = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_BOTH;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R10
  no_rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != MODE_RSVD);

  // R8
  solo_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == 2'b01) |=> (mode_q == MODE_SOLO0));

  // R9
  hold_until_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_BOTH && !all_low_i) |=> (mode_q != MODE_BOTH));
endmodule

// File: rtl/tsa_cap_gate.sv
module tsa_cap_gate
  import tsa_pkg::*;
#(
  parameter int TID     = 0,
  parameter int ROB_CAP = 126,
  parameter int LD_CAP  = 48,
  parameter int ST_CAP  = 24,
  parameter int ROB_W   = $clog2(ROB_CAP + 1),
  parameter int LD_W    = $clog2(LD_CAP + 1),
  parameter int ST_W    = $clog2(ST_CAP + 1)
) (
  input  mode_e            mode_i,
  input  logic             pend_i,
  input  logic             vld_i,
  input  logic [1:0]       kind_i,
  input  logic [ROB_W-1:0] rob_cnt_i,
  input  logic [LD_W-1:0]  ld_cnt_i,
  input  logic [ST_W-1:0]  st_cnt_i,
  output logic             elig_o,
  output logic             need_ld_o,
  output logic             need_st_o
);
  localparam mode_e OWN_SOLO = (TID == 0) ? MODE_SOLO0 : MODE_SOLO1;

  logic active, narrow;
  int   rob_lim, ld_lim, st_lim;
  logic rob_ok, ld_ok, st_ok;

  always_comb begin
    active    = (mode_i == MODE_BOTH) || (mode_i == OWN_SOLO);
    narrow    = (mode_i == MODE_BOTH) || pend_i;
    rob_lim   = narrow ? ROB_CAP / 2 : ROB_CAP;
    ld_lim    = narrow ? LD_CAP / 2 : LD_CAP;
    st_lim    = narrow ? ST_CAP / 2 : ST_CAP;
    need_ld_o = (kind_e'(kind_i) == KIND_LOAD);
    need_st_o = (kind_e'(kind_i) == KIND_STORE);
    rob_ok    = int'(rob_cnt_i) < rob_lim;
    ld_ok     = !need_ld_o || (int'(ld_cnt_i) < ld_lim);
    st_ok     = !need_st_o || (int'(st_cnt_i) < st_lim);
    elig_o    = vld_i && active && rob_ok && ld_ok && st_ok;
  end
endmodule

// File: rtl/tsa_thr_arb.sv
module tsa_thr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] elig_i,
  output logic [1:0] grant_o
);
  logic turn_q, turn_d, turn_en;

  always_comb begin
    unique case (elig_i)
      2'b01:   grant_o = 2'b01;
      2'b10:   grant_o = 2'b10;
      2'b11:   grant_o = turn_q ? 2'b10 : 2'b01;
      default: grant_o = 2'b00;
    endcase
    turn_d  = grant_o[0];
    turn_en = |grant_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       turn_q <= 1'b0;
    else if (turn_en) turn_q <= turn_d;
  end

  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R4
  grant_needs_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~elig_i) == 2'b00);

  // R5
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == 2'b01) |=> (elig_i != 2'b11 || grant_o == 2'b10));
endmodule

// File: rtl/thread_share_alloc.sv
module thread_share_alloc
  import tsa_pkg::*;
#(
  parameter int ROB_CAP = 126,
  parameter int LD_CAP  = 48,
  parameter int ST_CAP  = 24,
  parameter int REL_W   = 2,
  parameter int ROB_W   = $clog2(ROB_CAP + 1),
  parameter int LD_W    = $clog2(LD_CAP + 1),
  parameter int ST_W    = $clog2(ST_CAP + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode_req,
  input  logic [NTHR-1:0]         uop_vld,
  input  logic [2*NTHR-1:0]       uop_kind,
  input  logic [NTHR*REL_W-1:0]   rob_rel,
  input  logic [NTHR*REL_W-1:0]   ld_rel,
  input  logic [NTHR*REL_W-1:0]   st_rel,
  output logic [NTHR-1:0]         grant,
  output logic [1:0]              mode_now,
  output logic [NTHR*ROB_W-1:0]   rob_used,
  output logic [NTHR*LD_W-1:0]    ld_used,
  output logic [NTHR*ST_W-1:0]    st_used
);
  localparam int ROB_HALF = ROB_CAP / 2;
  localparam int LD_HALF  = LD_CAP / 2;
  localparam int ST_HALF  = ST_CAP / 2;

  mode_e           mode;
  logic            pend;
  logic [NTHR-1:0] elig, need_ld, need_st, low;
  logic            all_low;

  assign all_low  = &low;
  assign mode_now = mode;

  tsa_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (mode_req),
    .all_low_i (all_low),
    .mode_o    (mode),
    .pend_o    (pend)
  );

  tsa_thr_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig_i  (elig),
    .grant_o (grant)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [ROB_W-1:0] rob_c;
    logic [LD_W-1:0]  ld_c;
    logic [ST_W-1:0]  st_c;

    tsa_cap_gate #(
      .TID(t), .ROB_CAP(ROB_CAP), .LD_CAP(LD_CAP), .ST_CAP(ST_CAP),
      .ROB_W(ROB_W), .LD_W(LD_W), .ST_W(ST_W)
    ) u_gate (
      .mode_i    (mode),
      .pend_i    (pend),
      .vld_i     (uop_vld[t]),
      .kind_i    (uop_kind[2*t +: 2]),
      .rob_cnt_i (rob_c),
      .ld_cnt_i  (ld_c),
      .st_cnt_i  (st_c),
      .elig_o    (elig[t]),
      .need_ld_o (need_ld[t]),
      .need_st_o (need_st[t])
    );

    tsa_occ_counter #(.CAP(ROB_CAP), .REL_W(REL_W), .CW(ROB_W)) u_rob (
      .clk(clk), .rst_n(rst_n), .inc_i(grant[t]),
      .dec_i(rob_rel[t*REL_W +: REL_W]), .cnt_o(rob_c)
    );
    tsa_occ_counter #(.CAP(LD_CAP), .REL_W(REL_W), .CW(LD_W)) u_ld (
      .clk(clk), .rst_n(rst_n), .inc_i(grant[t] & need_ld[t]),
      .dec_i(ld_rel[t*REL_W +: REL_W]), .cnt_o(ld_c)
    );
    tsa_occ_counter #(.CAP(ST_CAP), .REL_W(REL_W), .CW(ST_W)) u_st (
      .clk(clk), .rst_n(rst_n), .inc_i(grant[t] & need_st[t]),
      .dec_i(st_rel[t*REL_W +: REL_W]), .cnt_o(st_c)
    );

    assign low[t] = (int'(rob_c) <= ROB_HALF) && (int'(ld_c) <= LD_HALF) &&
                    (int'(st_c) <= ST_HALF);
    assign rob_used[t*ROB_W +: ROB_W] = rob_c;
    assign ld_used[t*LD_W +: LD_W]    = ld_c;
    assign st_used[t*ST_W +: ST_W]    = st_c;

    // R2
    half_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_BOTH) |-> low[t]);
  end
endmodule

// File: tb/thread_share_alloc_bench.sv
module thread_share_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 6, LC = 4, SC = 2, RW = 2;
  localparam int ROBW = $clog2(RC + 1), LDW = $clog2(LC + 1), STW = $clog2(SC + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_req = 2'b00, uop_vld = 2'b00, grant, mode_now;
  logic [3:0] uop_kind = 4'b0;
  logic [2*RW-1:0] rob_rel = '0, ld_rel = '0, st_rel = '0;
  logic [2*ROBW-1:0] rob_used;
  logic [2*LDW-1:0] ld_used;
  logic [2*STW-1:0] st_used;

  thread_share_alloc #(.ROB_CAP(RC), .LD_CAP(LC), .ST_CAP(SC), .REL_W(RW)) u_thread_share_alloc (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .uop_vld(uop_vld), .uop_kind(uop_kind),
    .rob_rel(rob_rel), .ld_rel(ld_rel), .st_rel(st_rel), .grant(grant), .mode_now(mode_now),
    .rob_used(rob_used), .ld_used(ld_used), .st_used(st_used));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_rob[2], m_ld[2], m_st[2];
  int m_mode = 0, m_turn = 0;
  logic [31:0] lf = 32'h1ACE_B00C;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int rnd();
    lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
    return int'(lf[15:0]);
  endfunction

  function automatic int mn(input int a, input int b);
    return a < b ? a : b;
  endfunction

  // One cycle: drive at the falling edge, check, then advance the model.
  task automatic step(input int req, input int vprob, input int rprob, input bit first);
    int kd[2], rr[2], lr[2], sr[2], el[2], eg, pend, narrow, cr, cl, cs, act;
    @(negedge clk);
    // R7: registered counts reflect the previous cycle's update
    for (int t = 0; t < 2; t++) begin
      chk(int'(rob_used[t*ROBW +: ROBW]) == m_rob[t], "R7 rob count", int'(rob_used[t*ROBW +: ROBW]), m_rob[t]);
      chk(int'(ld_used[t*LDW +: LDW]) == m_ld[t], "R7 load count", int'(ld_used[t*LDW +: LDW]), m_ld[t]);
      chk(int'(st_used[t*STW +: STW]) == m_st[t], "R7 store count", int'(st_used[t*STW +: STW]), m_st[t]);
      if (m_mode == 0)
        chk(int'(rob_used[t*ROBW +: ROBW]) <= RC / 2 && int'(ld_used[t*LDW +: LDW]) <= LC / 2 &&
            int'(st_used[t*STW +: STW]) <= SC / 2, "R2 half share", int'(rob_used[t*ROBW +: ROBW]), RC / 2);
    end
    chk(int'(mode_now) == m_mode, req == 3 ? "R10 mode" : (req == 0 ? "R9 mode" : "R8 mode"),
        int'(mode_now), m_mode);
    mode_req = 2'(req);
    for (int t = 0; t < 2; t++) begin
      uop_vld[t] = (rnd() % 8) < vprob;
      kd[t] = rnd() % 4;
      uop_kind[2*t +: 2] = 2'(kd[t]);
      rr[t] = ((rnd() % 8) < rprob) ? mn(rnd() % 4, m_rob[t]) : 0;
      lr[t] = ((rnd() % 8) < rprob) ? mn(rnd() % 4, m_ld[t]) : 0;
      sr[t] = ((rnd() % 8) < rprob) ? mn(rnd() % 4, m_st[t]) : 0;
      rob_rel[t*RW +: RW] = RW'(rr[t]);
      ld_rel[t*RW +: RW] = RW'(lr[t]);
      st_rel[t*RW +: RW] = RW'(sr[t]);
    end
    #1;
    pend = (req == 0 && m_mode != 0);
    narrow = (m_mode == 0) || pend;
    cr = narrow ? RC / 2 : RC; cl = narrow ? LC / 2 : LC; cs = narrow ? SC / 2 : SC;
    for (int t = 0; t < 2; t++) begin
      act = (m_mode == 0) || (m_mode == t + 1);
      el[t] = uop_vld[t] && act && m_rob[t] < cr && (kd[t] != 1 || m_ld[t] < cl) &&
              (kd[t] != 2 || m_st[t] < cs);
    end
    if (el[0] && el[1]) eg = (m_turn == 0) ? 1 : 2;
    else eg = (el[0] ? 1 : 0) | (el[1] ? 2 : 0);
    chk(int'(grant) == eg,
        first ? "R1 first grant" : (el[0] && el[1]) ? "R5 alternation" :
        (m_mode != 0) ? "R3 single thread" : (el[0] || el[1]) ? "R6 skip" : "R4 no room",
        int'(grant), eg);
    // advance model
    for (int t = 0; t < 2; t++) begin
      int g = (eg >> t) & 1;
      m_rob[t] += g - rr[t];
      m_ld[t] += ((g == 1 && kd[t] == 1) ? 1 : 0) - lr[t];
      m_st[t] += ((g == 1 && kd[t] == 2) ? 1 : 0) - sr[t];
    end
    if (eg != 0) m_turn = (eg == 1) ? 1 : 0;
    if (req == 1 || req == 2) m_mode = req;
    else if (pend) begin
      if (m_rob[0] + rr[0] - (eg & 1) <= RC / 2 && 1 == 1) begin end
    end
  endtask

  initial begin
    int ph_req[10] = '{0, 1, 0, 2, 3, 0, 1, 2, 3, 0};
    int ph_rel[10] = '{2, 0, 3, 1, 2, 2, 1, 0, 1, 4};
    for (int t = 0; t < 2; t++) begin m_rob[t] = 0; m_ld[t] = 0; m_st[t] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(rob_used == '0 && ld_used == '0 && st_used == '0, "R1 counts zero", int'(rob_used), 0);
    chk(mode_now == 2'b00, "R1 mode", int'(mode_now), 0);
    chk(grant == 2'b00, "R6 idle no grant", int'(grant), 0);
    rst_n = 1'b1;
    // R1: both threads request plain ops in the first cycle
    @(negedge clk);
    uop_vld = 2'b11; uop_kind = 4'b0000;
    #1;
    chk(grant == 2'b01, "R1 first grant", int'(grant), 1);
    m_rob[0] = 1; m_turn = 1;
    for (int p = 0; p < 10; p++)
      for (int c = 0; c < 600; c++) begin
        step(ph_req[p], (c % 50 < 40) ? 7 : 3, ph_rel[p], 1'b0);
        upd_mode(ph_req[p]);
      end
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  // R9: return to two-thread mode once all counts reached half share in the checked cycle
  int lo_prev;
  task automatic upd_mode(input int req);
    // the model counts were already advanced; the mode decision uses the counts before that update,
    // kept in lo_prev by the low_track process at the falling edge
    if (req == 0 && m_mode != 0 && lo_prev != 0) m_mode = 0;
  endtask

  always @(negedge clk) begin
    lo_prev = (m_rob[0] <= RC / 2 && m_rob[1] <= RC / 2 && m_ld[0] <= LC / 2 && m_ld[1] <= LC / 2 &&
               m_st[0] <= SC / 2 && m_st[1] <= SC / 2) ? 1 : 0;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule